// File: doc/BRIEF.md
# Staggered Per-Device Refresh Scheduler

This block schedules refresh for one rank made of several DRAM devices that share command timing. Instead of refreshing the same rows of every device at once, it refreshes a single device per refresh slot and rotates through the devices. The other devices in the rank stay free for column reads, and the data on the device being refreshed can be rebuilt from the others.

A free-running interval timer divides the per-device refresh interval by the number of devices, so each device still gets its full quota of refreshes per retention window. When the high-temperature input is set, the slot length is halved, which doubles the refresh rate. For each device the block tracks whether a row is open, from the controller's own activate and precharge commands. When the target device has an open row, the block precharges it, waits the precharge time, refreshes it for the refresh cycle time, and then re-opens the row. It reports which device is under maintenance and a busy flag.

Top module: `srf_sched`

## Requirements
- R1: While reset is held and on the first cycle after it is released, all command outputs are zero, `busy_o` is low and `ref_idx_o` is 0.
- R2: With `hot_i` low, refresh slots start every T_REFI/N_DEV cycles. The first slot's command appears T_REFI/N_DEV+1 cycles after reset release.
- R3: With `hot_i` high, slots start every T_REFI/(2*N_DEV) cycles, counted from the last slot boundary.
- R4: Slots serve devices in round-robin order 0,1,...,N_DEV-1,0,... While a device is served, `busy_o` is high and `ref_idx_o` holds that device number. Every command bit issued is the bit at that index.
- R5: In any cycle, at most one bit of `pre_o`, `ref_o` and `act_o` taken together is set.
- R6: If the served device has an open row, a one-cycle `pre_o` pulse comes first. `ref_o` follows T_RP cycles later, and no device is refreshed while its row is still open.
- R7: If the served device has no open row, `ref_o` is issued in the slot's first cycle without a precharge.
- R8: `busy_o` stays high for T_RFC cycles starting with the `ref_o` cycle. If a row was closed for the refresh, a one-cycle `act_o` follows, and `busy_o` then falls. Otherwise `busy_o` falls right after the T_RFC cycles.
- R9: `ref_idx_o` never changes while `busy_o` is high, and it advances by one (with wrap) when `busy_o` falls.
- R10: `act_i` and `pre_i` for the device being served are ignored. A precharge requested during that device's refresh does not prevent its row from being re-opened.
- R11: Between consecutive `ref_o` pulses, and from reset release to the first one, there are never more than T_REFI/N_DEV+T_RP+2 cycles.
- R12: `act_i` for a device not being served is recorded during another device's refresh. That device's next slot then starts with a precharge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | High-temperature operation; halves the refresh slot |
| act_i | input | N_DEV | Controller opened a row on device d |
| pre_i | input | N_DEV | Controller closed the row on device d |
| pre_o | output | N_DEV | One-cycle precharge command for device d |
| ref_o | output | N_DEV | One-cycle refresh command for device d |
| act_o | output | N_DEV | One-cycle row re-open command for device d |
| ref_idx_o | output | max(1,clog2(N_DEV)) | Device under maintenance; meaningful while busy |
| busy_o | output | 1 | A device is in precharge, refresh or re-open |

## Verification
The bench covers slots on closed devices (a bare refresh followed by exactly T_RFC busy cycles) and slots on open devices (precharge, refresh, re-open). Comparing the two separates the precharge path from the direct path. The temperature input is switched on and off at slot boundaries, so a wrong slot length shows up as a shifted command cycle. Controller precharges are sent both to the device under refresh, where they must have no effect, and to an idle device, where they must close the row. An activate is sent to another device during a refresh, to show that tracking continues for devices outside the slot.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_REF  = 2'd2,
        ST_ACT  = 2'd3
    } srf_state_e;

endpackage

// File: rtl/srf_interval_timer.sv
module srf_interval_timer #(
    parameter int SLOT_CYC = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    output logic tick_o
);
    localparam int TW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [TW-1:0] COLD_LAST = TW'(SLOT_CYC - 1);
    localparam logic [TW-1:0] HOT_LAST  = TW'(SLOT_CYC / 2 - 1);

    logic [TW-1:0] tmr_d, tmr_q;
    logic [TW-1:0] last;

    always_comb begin
        last   = hot_i ? HOT_LAST : COLD_LAST;
        tick_o = (tmr_q >= last);
        tmr_d  = tick_o ? '0 : tmr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/srf_bank_track.sv
module srf_bank_track (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic lock_i,
    input  logic clr_i,
    input  logic set_i,
    output logic open_o
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (set_i)       open_d = 1'b1;
        else if (clr_i)  open_d = 1'b0;
        else if (!lock_i) begin
            if (act_i)      open_d = 1'b1;
            else if (pre_i) open_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign open_o = open_q;
endmodule

// File: rtl/srf_sched.sv
module srf_sched
    import srf_pkg::*;
#(
    parameter int N_DEV  = 8,
    parameter int T_REFI = 3120,
    parameter int T_RP   = 6,
    parameter int T_RFC  = 104
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hot_i,
    input  logic [N_DEV-1:0]                      act_i,
    input  logic [N_DEV-1:0]                      pre_i,
    output logic [N_DEV-1:0]                      pre_o,
    output logic [N_DEV-1:0]                      ref_o,
    output logic [N_DEV-1:0]                      act_o,
    output logic [(N_DEV>1?$clog2(N_DEV):1)-1:0]  ref_idx_o,
    output logic                                  busy_o
);
    localparam int SLOT_CYC = T_REFI / N_DEV;
    localparam int IDXW     = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int CMAX     = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int CW       = $clog2(CMAX) + 1;
    localparam logic [CW-1:0]   RP_LAST  = CW'(T_RP - 1);
    localparam logic [CW-1:0]   RFC_LAST = CW'(T_RFC - 1);
    localparam logic [IDXW-1:0] IDX_TOP  = IDXW'(N_DEV - 1);

    typedef struct packed {
        srf_state_e      st;
        logic [CW-1:0]   cnt;
        logic [IDXW-1:0] idx;
        logic            due;
        logic            reopen;
    } sched_t;

    sched_t r_d, r_q;

    logic             tick;
    logic [N_DEV-1:0] open_w;
    logic [N_DEV-1:0] sel;
    logic [N_DEV-1:0] lock;
    logic             target_open;

    srf_interval_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    always_comb begin
        sel  = N_DEV'(1) << r_q.idx;
        lock = ((r_q.st != ST_IDLE) || r_q.due) ? sel : '0;
    end

    for (genvar d = 0; d < N_DEV; d++) begin : g_bank
        srf_bank_track u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (act_i[d]),
            .pre_i  (pre_i[d]),
            .lock_i (lock[d]),
            .clr_i  (pre_o[d]),
            .set_i  (act_o[d]),
            .open_o (open_w[d])
        );
    end

    assign target_open = |(open_w & sel);

    always_comb begin
        r_d     = r_q;
        r_d.due = tick | r_q.due;
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.due) begin
                    r_d.due    = tick;
                    r_d.reopen = target_open;
                    r_d.st     = target_open ? ST_PRE : ST_REF;
                    r_d.cnt    = target_open ? RP_LAST : RFC_LAST;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_REF;
                    r_d.cnt = RFC_LAST;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_REF: begin
                if (r_q.cnt == '0) begin
                    if (r_q.reopen) begin
                        r_d.st = ST_ACT;
                    end else begin
                        r_d.st  = ST_IDLE;
                        r_d.idx = (r_q.idx == IDX_TOP) ? '0 : r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                r_d.st     = ST_IDLE;
                r_d.reopen = 1'b0;
                r_d.idx    = (r_q.idx == IDX_TOP) ? '0 : r_q.idx + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.idx    <= '0;
            r_q.due    <= 1'b0;
            r_q.reopen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        pre_o     = (r_q.st == ST_PRE && r_q.cnt == RP_LAST)  ? sel : '0;
        ref_o     = (r_q.st == ST_REF && r_q.cnt == RFC_LAST) ? sel : '0;
        act_o     = (r_q.st == ST_ACT) ? sel : '0;
        busy_o    = (r_q.st != ST_IDLE);
        ref_idx_o = r_q.idx;
    end
endmodule

// File: rtl/srf_sched_chk.sv
module srf_sched_chk #(
    parameter int N_DEV  = 8,
    parameter int T_REFI = 3120,
    parameter int T_RP   = 6
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [N_DEV-1:0]                      pre_o,
    input logic [N_DEV-1:0]                      ref_o,
    input logic [N_DEV-1:0]                      act_o,
    input logic [(N_DEV>1?$clog2(N_DEV):1)-1:0]  ref_idx_o,
    input logic                                  busy_o,
    input logic [N_DEV-1:0]                      row_open
);
    localparam int GAP_MAX = T_REFI / N_DEV + T_RP + 2;

    logic [N_DEV-1:0] cmd;
    int gap_q;

    assign cmd = pre_o | ref_o | act_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     gap_q <= 0;
        else if (|ref_o) gap_q <= 1;
        else            gap_q <= gap_q + 1;
    end

    p_one_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd) && $onehot0({|pre_o, |ref_o, |act_o}));

    p_closed_at_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ref_o) |-> ((ref_o & row_open) == '0));

    p_cmd_on_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd) |-> (busy_o && cmd == (N_DEV'(1) << ref_idx_o)));

    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ref_idx_o));

    p_idx_moves_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_idx_o) |-> !busy_o);

    p_reopen_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_o) |=> !busy_o);

    p_no_overdue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_MAX);
endmodule

bind srf_sched srf_sched_chk #(
    .N_DEV  (N_DEV),
    .T_REFI (T_REFI),
    .T_RP   (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_o     (pre_o),
    .ref_o     (ref_o),
    .act_o     (act_o),
    .ref_idx_o (ref_idx_o),
    .busy_o    (busy_o),
    .row_open  (open_w)
);

// File: tb/tb_srf_sched.sv
module tb_srf_sched;
    localparam int N_DEV  = 4;
    localparam int T_REFI = 64;
    localparam int T_RP   = 2;
    localparam int T_RFC  = 4;
    localparam int SLOT   = T_REFI / N_DEV;
    localparam int GAP_MAX = SLOT + T_RP + 2;

    typedef enum int {K_PRE, K_REF, K_ACT, K_IDLE} kind_e;
    typedef struct {
        kind_e kind;
        int    dev;
        int    cyc;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hot_i = 1'b0;
    logic [N_DEV-1:0] act_i = '0;
    logic [N_DEV-1:0] pre_i = '0;
    logic [N_DEV-1:0] pre_o, ref_o, act_o;
    logic [1:0]       ref_idx_o;
    logic             busy_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    item_t exp_q[$];

    srf_sched #(.N_DEV(N_DEV), .T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC)) dut (
        .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .act_i(act_i), .pre_i(pre_i),
        .pre_o(pre_o), .ref_o(ref_o), .act_o(act_o),
        .ref_idx_o(ref_idx_o), .busy_o(busy_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input kind_e k, input int d, input int c, input string tag);
        item_t it;
        it.kind = k; it.dev = d; it.cyc = c; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic at_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int vec_idx(input logic [N_DEV-1:0] v);
        int r = -1;
        for (int i = 0; i < N_DEV; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: pops expected items and compares against observed events
    logic prev_busy = 1'b0;
    logic [1:0] busy_idx = '0;
    bit idx_moved = 0;
    int last_ref = 0;
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            bit    ev;
            kind_e k;
            int    d;
            ev = 0; k = K_IDLE; d = -1;
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                check(0, exp_q[0].tag, "missing event kind", -1, int'(exp_q[0].kind));
                void'(exp_q.pop_front());
            end
            if (|(pre_o | ref_o | act_o)) begin
                check($onehot(pre_o | ref_o | act_o) &&
                      ($countones({|pre_o, |ref_o, |act_o}) == 1),
                      "R5", "command bits set", $countones(pre_o | ref_o | act_o), 1);
                ev = 1;
                if (|pre_o)      begin k = K_PRE; d = vec_idx(pre_o); end
                else if (|ref_o) begin k = K_REF; d = vec_idx(ref_o); end
                else             begin k = K_ACT; d = vec_idx(act_o); end
                check(busy_o && int'(ref_idx_o) == d, "R4", "index at command",
                      int'(ref_idx_o), d);
            end else if (prev_busy && !busy_o) begin
                ev = 1; k = K_IDLE; d = -1;
                check(!idx_moved, "R9", "index held while busy", 1, 0);
                check(int'(ref_idx_o) == (int'(busy_idx) + 1) % N_DEV, "R9",
                      "index after slot", int'(ref_idx_o), (int'(busy_idx) + 1) % N_DEV);
            end
            if (busy_o && prev_busy && ref_idx_o != busy_idx) idx_moved = 1;
            if (busy_o && !prev_busy) begin busy_idx = ref_idx_o; idx_moved = 0; end
            if (k == K_REF && ev) begin
                check(cyc - last_ref <= GAP_MAX, "R11", "gap between refreshes",
                      cyc - last_ref, GAP_MAX);
                last_ref = cyc;
            end
            if (ev) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected event kind", int'(k), -1);
                end else begin
                    check(exp_q[0].kind == k, exp_q[0].tag, "event kind", int'(k), int'(exp_q[0].kind));
                    check(exp_q[0].dev == d,  exp_q[0].tag, "event device", d, exp_q[0].dev);
                    check(exp_q[0].cyc == cyc, exp_q[0].tag, "event cycle", cyc, exp_q[0].cyc);
                    void'(exp_q.pop_front());
                end
            end
            prev_busy = busy_o;
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        check(0, "R11", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        // expected schedule: slot boundary k*SLOT, command one cycle later
        expect_ev(K_REF, 0, 17, "R2");  expect_ev(K_IDLE, -1, 21, "R8");
        expect_ev(K_PRE, 1, 33, "R6");  expect_ev(K_REF, 1, 35, "R6");
        expect_ev(K_ACT, 1, 39, "R8");  expect_ev(K_IDLE, -1, 40, "R8");
        expect_ev(K_REF, 2, 49, "R7");  expect_ev(K_IDLE, -1, 53, "R8");
        expect_ev(K_PRE, 3, 65, "R6");  expect_ev(K_REF, 3, 67, "R6");
        expect_ev(K_ACT, 3, 71, "R10"); expect_ev(K_IDLE, -1, 72, "R8");
        expect_ev(K_REF, 0, 81, "R4");  expect_ev(K_IDLE, -1, 85, "R8");
        expect_ev(K_PRE, 1, 89, "R3");  expect_ev(K_REF, 1, 91, "R3");
        expect_ev(K_ACT, 1, 95, "R8");  expect_ev(K_IDLE, -1, 96, "R8");
        expect_ev(K_REF, 2, 97, "R3");  expect_ev(K_IDLE, -1, 101, "R8");
        expect_ev(K_PRE, 3, 105, "R3"); expect_ev(K_REF, 3, 107, "R3");
        expect_ev(K_ACT, 3, 111, "R8"); expect_ev(K_IDLE, -1, 112, "R8");
        expect_ev(K_REF, 0, 113, "R3"); expect_ev(K_IDLE, -1, 117, "R8");
        expect_ev(K_PRE, 1, 129, "R2"); expect_ev(K_REF, 1, 131, "R2");
        expect_ev(K_ACT, 1, 135, "R8"); expect_ev(K_IDLE, -1, 136, "R8");
        expect_ev(K_REF, 2, 145, "R2"); expect_ev(K_IDLE, -1, 149, "R8");
        expect_ev(K_REF, 3, 161, "R7"); expect_ev(K_IDLE, -1, 165, "R8");
        expect_ev(K_PRE, 0, 177, "R12"); expect_ev(K_REF, 0, 179, "R12");
        expect_ev(K_ACT, 0, 183, "R12"); expect_ev(K_IDLE, -1, 184, "R8");

        repeat (3) @(negedge clk);
        check(pre_o == '0 && ref_o == '0 && act_o == '0, "R1", "commands in reset",
              int'(pre_o | ref_o | act_o), 0);
        check(!busy_o && ref_idx_o == '0, "R1", "busy/index in reset",
              int'({busy_o, ref_idx_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && ref_idx_o == '0 && (pre_o | ref_o | act_o) == '0, "R1",
              "first cycle after reset", int'({busy_o, ref_idx_o}), 0);

        at_cyc(20);  act_i[1] = 1'b1; @(negedge clk); act_i = '0;   // open row on device 1
        at_cyc(50);  act_i[3] = 1'b1; @(negedge clk); act_i = '0;   // open row on device 3
        at_cyc(68);  pre_i[3] = 1'b1; @(negedge clk); pre_i = '0;   // R10: ignored during refresh
        at_cyc(80);  hot_i = 1'b1;                                  // R3: hot from a slot boundary
        at_cyc(112); hot_i = 1'b0;
        at_cyc(120); pre_i[3] = 1'b1; @(negedge clk); pre_i = '0;   // close device 3 while idle
        at_cyc(146); act_i[0] = 1'b1; @(negedge clk); act_i = '0;   // R12: other device during refresh
        at_cyc(192);
        check(exp_q.size() == 0, "R2", "expected events left", exp_q.size(), 0);
        finish_run();
    end
endmodule